// File: doc/BRIEF.md
# Pipelined Normalized Reciprocal and Quotient Unit

The block turns an unsigned fixed-point operand into its reciprocal in a quasi-floating-point form: a mantissa in [1, 2) together with a shift exponent. The operand `in_x` is read as the fraction `in_x / 2^IN_W`. A leading-one search gives the shift count, and the shift moves the operand into the range [0.5, 1). The bits just below the leading one address a computed seed table. Then one or two Newton-Raphson steps, each built from two multipliers, refine that seed. The caller applies the factor `2^exp` wherever it is cheapest to do so. The exponent therefore leaves the unit untouched.

When the quotient option is enabled, the unit also multiplies the finished mantissa by a second operand `in_num`. This gives the mantissa of `in_num / in_x`, which shares the same exponent. The datapath is fully pipelined. It accepts one operand per clock and produces each result a fixed number of cycles later. The `SEED_BITS` parameter chooses the variant. A wide table needs one refinement step. A narrow table needs two steps, and the pipeline is then two stages longer.

Top module: `nrr_recip`

## Requirements
- R1: While `rst_n` is low and until the first accepted operand has travelled through the pipeline, `out_valid` stays 0.
- R2: Each cycle with `in_valid` high yields exactly one cycle with `out_valid` high, LAT = 3 + 2·ITERS cycles later. ITERS is 1 when `SEED_BITS` ≥ 8 and 2 otherwise, so LAT is 5 for the default and 7 for `SEED_BITS` = 4. Back-to-back operands are accepted on every cycle.
- R3: For a nonzero operand, `out_exp` equals the number of leading zeros of `in_x` in IN_W bits, so `in_x·2^out_exp` has bit IN_W−1 set.
- R4: For a nonzero operand, `out_mant` is unsigned with F = MANT_W−1 fraction bits. It lies within 2 units of the last place of the exact value 2^(IN_W−out_exp)/in_x · 2^F, for both table variants.
- R5: When the rounded mantissa reaches 2.0, `out_mant` saturates to all ones (2^MANT_W−1). A power-of-two operand always gives all ones.
- R6: A zero operand sets `out_dz` = 1, `out_mant` to all ones and `out_exp` = 0. A nonzero operand gives `out_dz` = 0.
- R7: With `QUOT_EN` = 1, `out_quot` = floor(in_num·out_mant / 2^F), so in_num/in_x ≈ out_quot·2^(out_exp−IN_W). With `QUOT_EN` = 0, `out_quot` is 0.
- R8: Results appear in the order the operands were accepted. An idle cycle (`in_valid` low) produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_x | input | IN_W | Divisor operand, read as in_x/2^IN_W |
| in_num | input | IN_W | Dividend for the optional quotient |
| out_valid | output | 1 | Result present this cycle |
| out_mant | output | MANT_W | Reciprocal mantissa, F = MANT_W−1 fraction bits |
| out_exp | output | $clog2(IN_W) | Normalization shift count |
| out_dz | output | 1 | Operand was zero |
| out_quot | output | IN_W+1 | Quotient mantissa in_num·out_mant/2^F |

## Verification
The bench feeds both table variants the same operands. These include zero, one, every power of two, values just above and below the normalization boundary (0x7FFF, 0x8000, 0x8001), all-ones and a long run of random operands, some separated by idle cycles. Powers of two show whether the saturation path engages, because there the exact normalized reciprocal is 2.0. Values just above 0x8000 stress seed entry zero. All-ones probes the lower end of the mantissa range. Zero separates the divide-by-zero path from normal normalization. Random operands with idle cycles mixed in test the latency, the ordering and the absence of spurious results. Each random operand is also compared against a real-valued reference for both one-step and two-step refinement.

// File: rtl/nrr_pkg.sv
package nrr_pkg;

   // Seed for table entry idx: reciprocal of the midpoint of the interval
   // [ (2^sb+idx)/2^(sb+1), (2^sb+idx+1)/2^(sb+1) ), with fb fraction bits.
   function automatic longint unsigned nrr_seed(input int idx, input int sb, input int fb);
      longint unsigned num;
      longint unsigned den;
      num = 64'd1 << (fb + sb + 2);
      den = (64'd1 << (sb + 1)) + 64'(2 * idx + 1);
      return num / den;
   endfunction

   // Refinement steps needed for a given seed address width.
   function automatic int nrr_iters(input int sb);
      return (sb >= 8) ? 1 : 2;
   endfunction

endpackage

// File: rtl/nrr_norm.sv
module nrr_norm #(
   parameter int IN_W  = 16,
   parameter int FB    = 18,
   parameter int EXP_W = 4
) (
   input  logic [IN_W-1:0]  x_i,
   output logic [FB-1:0]    z_o,
   output logic [EXP_W-1:0] sh_o,
   output logic             zero_o
);

   logic [IN_W-1:0] shifted;

   always_comb begin
      sh_o = '0;
      for (int i = 0; i < IN_W; i++) begin
         if (x_i[i]) sh_o = EXP_W'(IN_W - 1 - i);
      end
      shifted = x_i << sh_o;
      z_o     = FB'(shifted) << (FB - IN_W);
      zero_o  = (x_i == '0);
   end

endmodule

// File: rtl/nrr_seed_lut.sv
module nrr_seed_lut #(
   parameter int SB = 8,
   parameter int FB = 18,
   parameter int QW = 20
) (
   input  logic [SB-1:0] idx_i,
   output logic [QW-1:0] seed_o
);

   localparam int DEPTH = 1 << SB;

   logic [QW-1:0] rom [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_rom
      assign rom[g] = QW'(nrr_pkg::nrr_seed(g, SB, FB));
   end

   assign seed_o = rom[idx_i];

endmodule

// File: rtl/nrr_step.sv
module nrr_step #(
   parameter int FB     = 18,
   parameter int QW     = 20,
   parameter int SIDE_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_i,
   input  logic [FB-1:0]     z_i,
   input  logic [QW-1:0]     q_i,
   input  logic [SIDE_W-1:0] s_i,
   output logic              v_o,
   output logic [FB-1:0]     z_o,
   output logic [QW-1:0]     q_o,
   output logic [SIDE_W-1:0] s_o
);

   localparam int            PW  = FB + QW;
   localparam int            EW  = 2 * QW;
   localparam logic [QW-1:0] TWO = QW'(2) << FB;

   logic [PW-1:0]     zq;
   logic              a_v;
   logic [FB-1:0]     a_z;
   logic [QW-1:0]     a_q;
   logic [QW-1:0]     a_t;
   logic [SIDE_W-1:0] a_s;
   logic [QW-1:0]     err;
   logic [EW-1:0]     qe;

   assign zq  = PW'(z_i) * PW'(q_i);
   assign err = TWO - a_t;
   assign qe  = EW'(a_q) * EW'(err);

   // first half: z*q
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_v <= 1'b0;
         a_z <= '0;
         a_q <= '0;
         a_t <= '0;
         a_s <= '0;
      end else begin
         a_v <= v_i;
         a_z <= z_i;
         a_q <= q_i;
         a_t <= QW'(zq >> FB);
         a_s <= s_i;
      end
   end

   // second half: q*(2 - z*q)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o <= 1'b0;
         z_o <= '0;
         q_o <= '0;
         s_o <= '0;
      end else begin
         v_o <= a_v;
         z_o <= a_z;
         q_o <= QW'(qe >> FB);
         s_o <= a_s;
      end
   end

endmodule

// File: rtl/nrr_recip.sv
module nrr_recip #(
   parameter int IN_W      = 16,
   parameter int MANT_W    = 16,
   parameter int SEED_BITS = 8,
   parameter bit QUOT_EN   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [IN_W-1:0]          in_x,
   input  logic [IN_W-1:0]          in_num,
   output logic                     out_valid,
   output logic [MANT_W-1:0]        out_mant,
   output logic [$clog2(IN_W)-1:0]  out_exp,
   output logic                     out_dz,
   output logic [IN_W:0]            out_quot
);

   localparam int F       = MANT_W - 1;
   localparam int FB      = MANT_W + 2;
   localparam int QW      = FB + 2;
   localparam int EXP_W   = $clog2(IN_W);
   localparam int ITERS   = nrr_pkg::nrr_iters(SEED_BITS);
   localparam int LATENCY = 3 + 2 * ITERS;
   localparam int SIDE_W  = EXP_W + 1 + IN_W;
   localparam int QUOT_W  = IN_W + 1;
   localparam int PROD_W  = IN_W + MANT_W;
   localparam int RS      = FB - F;
   localparam logic [QW:0]         HALF     = (QW + 1)'(1) << (RS - 1);
   localparam logic [MANT_W-1:0]   MMAX     = '1;
   localparam logic [MANT_W+1:0]   MMAX_EXT = (MANT_W + 2)'(MMAX);

   // elaboration-time parameter checks
   if (IN_W < 4 || IN_W > 24) begin : g_bad_in_w
      $error("nrr_recip: IN_W must lie in 4..24");
   end
   if (IN_W > FB) begin : g_bad_fb
      $error("nrr_recip: IN_W must not exceed MANT_W+2");
   end
   if (MANT_W < 8 || MANT_W > 28) begin : g_bad_mant
      $error("nrr_recip: MANT_W must lie in 8..28");
   end
   if (SEED_BITS < 4 || SEED_BITS > 10) begin : g_bad_seed
      $error("nrr_recip: SEED_BITS must lie in 4..10");
   end

   // stage 1: normalization
   logic [FB-1:0]    n_z;
   logic [EXP_W-1:0] n_sh;
   logic             n_zero;

   nrr_norm #(.IN_W(IN_W), .FB(FB), .EXP_W(EXP_W)) u_norm (
      .x_i    (in_x),
      .z_o    (n_z),
      .sh_o   (n_sh),
      .zero_o (n_zero)
   );

   logic              s1_v;
   logic [FB-1:0]     s1_z;
   logic [SIDE_W-1:0] s1_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v <= 1'b0;
         s1_z <= '0;
         s1_s <= '0;
      end else begin
         s1_v <= in_valid;
         s1_z <= n_z;
         s1_s <= {n_sh, n_zero, in_num};
      end
   end

   // stage 2: seed lookup from the bits under the leading one
   logic [QW-1:0] seed;

   nrr_seed_lut #(.SB(SEED_BITS), .FB(FB), .QW(QW)) u_lut (
      .idx_i  (s1_z[FB-2 -: SEED_BITS]),
      .seed_o (seed)
   );

   logic              ch_v [ITERS+1];
   logic [FB-1:0]     ch_z [ITERS+1];
   logic [QW-1:0]     ch_q [ITERS+1];
   logic [SIDE_W-1:0] ch_s [ITERS+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_v[0] <= 1'b0;
         ch_z[0] <= '0;
         ch_q[0] <= '0;
         ch_s[0] <= '0;
      end else begin
         ch_v[0] <= s1_v;
         ch_z[0] <= s1_z;
         ch_q[0] <= seed;
         ch_s[0] <= s1_s;
      end
   end

   // refinement chain
   for (genvar k = 0; k < ITERS; k++) begin : g_iter
      nrr_step #(.FB(FB), .QW(QW), .SIDE_W(SIDE_W)) u_step (
         .clk   (clk),
         .rst_n (rst_n),
         .v_i   (ch_v[k]),
         .z_i   (ch_z[k]),
         .q_i   (ch_q[k]),
         .s_i   (ch_s[k]),
         .v_o   (ch_v[k+1]),
         .z_o   (ch_z[k+1]),
         .q_o   (ch_q[k+1]),
         .s_o   (ch_s[k+1])
      );
   end

   // final stage: round, saturate, optional quotient
   logic [SIDE_W-1:0] s_end;
   logic [EXP_W-1:0]  e_end;
   logic              dz_end;
   logic [IN_W-1:0]   num_end;
   logic [QW:0]       rnd;
   logic [MANT_W+1:0] m_full;
   logic [MANT_W-1:0] mant_c;
   logic [QUOT_W-1:0] quot_c;

   assign s_end   = ch_s[ITERS];
   assign e_end   = s_end[SIDE_W-1 -: EXP_W];
   assign dz_end  = s_end[IN_W];
   assign num_end = s_end[IN_W-1:0];
   assign rnd     = (QW + 1)'(ch_q[ITERS]) + HALF;
   assign m_full  = (MANT_W + 2)'(rnd >> RS);
   assign mant_c  = (dz_end || (m_full > MMAX_EXT)) ? MMAX : MANT_W'(m_full);

   if (QUOT_EN) begin : g_quot
      logic [PROD_W-1:0] prod;
      assign prod   = PROD_W'(num_end) * PROD_W'(mant_c);
      assign quot_c = QUOT_W'(prod >> F);
   end else begin : g_no_quot
      assign quot_c = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mant  <= '0;
         out_exp   <= '0;
         out_dz    <= 1'b0;
         out_quot  <= '0;
      end else begin
         out_valid <= ch_v[ITERS];
         out_mant  <= mant_c;
         out_exp   <= e_end;
         out_dz    <= dz_end;
         out_quot  <= quot_c;
      end
   end

endmodule

// File: rtl/nrr_recip_chk.sv
module nrr_recip_chk #(
   parameter int IN_W   = 16,
   parameter int MANT_W = 16,
   parameter int EXP_W  = 4,
   parameter int LAT    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [IN_W-1:0]   in_x,
   input logic              out_valid,
   input logic [MANT_W-1:0] out_mant,
   input logic [EXP_W-1:0]  out_exp,
   input logic              out_dz
);

   logic [LAT-1:0]  v_sr;
   logic [LAT-1:0]  z_sr;
   logic [IN_W-1:0] x_sr [LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_sr <= '0;
         z_sr <= '0;
      end else begin
         v_sr <= {v_sr[LAT-2:0], in_valid};
         z_sr <= {z_sr[LAT-2:0], in_valid && (in_x == '0)};
      end
   end

   always_ff @(posedge clk) begin
      x_sr[0] <= in_x;
      for (int i = 1; i < LAT; i++) x_sr[i] <= x_sr[i-1];
   end

   // R1 / R2: one result per accepted operand, fixed latency
   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v_sr[LAT-1]);

   // R6: flag tracks zero operands
   a_r6_dz_track: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_dz == z_sr[LAT-1]));

   // R6: zero operand saturates mantissa and clears exponent
   a_r6_dz_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_dz) |-> ((&out_mant) && (out_exp == '0)));

   // R3: exponent normalizes the operand
   a_r3_norm: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_dz) |->
         ((int'(x_sr[LAT-1]) >= (1 << (IN_W - 1 - int'(out_exp)))) &&
          (int'(x_sr[LAT-1]) <  (1 << (IN_W - int'(out_exp))))));

endmodule

bind nrr_recip nrr_recip_chk #(
   .IN_W   (IN_W),
   .MANT_W (MANT_W),
   .EXP_W  (EXP_W),
   .LAT    (LATENCY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_x      (in_x),
   .out_valid (out_valid),
   .out_mant  (out_mant),
   .out_exp   (out_exp),
   .out_dz    (out_dz)
);

// File: tb/nrr_recip_bench.sv
module nrr_recip_bench;

   localparam int CLK_P  = 10;
   localparam int IN_W   = 16;
   localparam int MANT_W = 16;
   localparam int F      = MANT_W - 1;
   localparam int EXP_W  = 4;
   localparam int LAT_A  = 5;   // SEED_BITS = 8: one refinement step
   localparam int LAT_B  = 7;   // SEED_BITS = 4: two refinement steps

   typedef struct {
      logic [IN_W-1:0] x;
      logic [IN_W-1:0] num;
      int              cyc;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [IN_W-1:0]   in_x = '0;
   logic [IN_W-1:0]   in_num = '0;

   logic              va, vb;
   logic [MANT_W-1:0] ma, mb;
   logic [EXP_W-1:0]  ea, eb;
   logic              da, db;
   logic [IN_W:0]     qa_o, qb_o;

   item_t qa[$];
   item_t qb[$];
   int    cyc = 0;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   nrr_recip u_nrr_recip (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_num(in_num),
      .out_valid(va), .out_mant(ma), .out_exp(ea), .out_dz(da), .out_quot(qa_o)
   );

   nrr_recip #(.SEED_BITS(4), .QUOT_EN(1'b0)) u_nrr_recip_narrow (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_num(in_num),
      .out_valid(vb), .out_mant(mb), .out_exp(eb), .out_dz(db), .out_quot(qb_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic check_item(input string dut, input item_t it, input int lat, input bit quot_on,
                             input logic [MANT_W-1:0] m, input logic [EXP_W-1:0] e,
                             input logic dz, input logic [IN_W:0] q);
      int     lz;
      real    mref, err;
      longint qexp;
      chk(cyc - it.cyc == lat, "R2", {dut, " latency"}, cyc - it.cyc, lat);
      lz = 0;
      for (int i = 0; i < IN_W; i++) if (it.x[i]) lz = IN_W - 1 - i;
      if (it.x == '0) begin
         chk(dz == 1'b1, "R6", {dut, " dz flag"}, dz, 1);
         chk(m == '1, "R6", {dut, " zero mantissa"}, m, (1 << MANT_W) - 1);
         chk(e == '0, "R6", {dut, " zero exponent"}, e, 0);
      end else begin
         chk(dz == 1'b0, "R6", {dut, " dz clear"}, dz, 0);
         chk(int'(e) == lz, "R3", {dut, " exponent"}, e, lz);
         mref = (2.0 ** (IN_W - lz + F)) / real'(it.x);
         err  = real'(m) - mref;
         if (err < 0.0) err = -err;
         chk(err <= 2.0, "R4", {dut, " mantissa"}, m, longint'($rtoi(mref)));
         if ($countones(it.x) == 1)
            chk(m == '1, "R5", {dut, " saturation"}, m, (1 << MANT_W) - 1);
      end
      qexp = quot_on ? ((longint'(it.num) * longint'(m)) >> F) : 0;
      chk(longint'(q) == qexp, "R7", {dut, " quotient"}, q, qexp);
   endtask

   // monitor: sample away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (va) begin
            if (qa.size() == 0) chk(1'b0, "R8", "wide spurious result", 1, 0);
            else check_item("wide", qa.pop_front(), LAT_A, 1'b1, ma, ea, da, qa_o);
         end
         if (vb) begin
            if (qb.size() == 0) chk(1'b0, "R8", "narrow spurious result", 1, 0);
            else check_item("narrow", qb.pop_front(), LAT_B, 1'b0, mb, eb, db, qb_o);
         end
      end
   end

   task automatic drive(input logic [IN_W-1:0] x, input logic [IN_W-1:0] num);
      item_t it;
      @(negedge clk);
      in_valid = 1'b1;
      in_x     = x;
      in_num   = num;
      it.x = x; it.num = num; it.cyc = cyc;
      qa.push_back(it);
      qb.push_back(it);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      in_x     = $urandom();
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(va == 1'b0, "R1", "wide valid in reset", va, 0);
      chk(vb == 1'b0, "R1", "narrow valid in reset", vb, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(va == 1'b0 && vb == 1'b0, "R1", "valid after reset", {va, vb}, 0);

      // edge operands
      drive(16'h0000, 16'h1234);
      drive(16'h0001, 16'hFFFF);
      drive(16'h0002, 16'h0000);
      drive(16'h0003, 16'h8000);
      drive(16'h7FFF, 16'h7FFF);
      drive(16'h8000, 16'h4321);
      drive(16'h8001, 16'hFFFF);
      drive(16'hFFFF, 16'hFFFF);
      drive(16'h00FF, 16'h0101);
      drive(16'h0100, 16'h0001);
      for (int i = 0; i < IN_W; i++) drive(IN_W'(1) << i, IN_W'($urandom()));
      idle();
      drive(16'h0000, 16'h0000);
      idle();
      idle();

      // random operands with bubbles
      for (int n = 0; n < 3000; n++) begin
         if (($urandom() & 3) == 0) idle();
         else drive(IN_W'($urandom()), IN_W'($urandom()));
      end
      idle();
      repeat (20) @(negedge clk);
      done = 1'b1;
      chk(qa.size() == 0, "R8", "wide pending results", qa.size(), 0);
      chk(qb.size() == 0, "R8", "narrow pending results", qb.size(), 0);
      report();
   end

endmodule